// File: doc/BRIEF.md
# Fault-Interval Resident Set Manager

This block keeps track of which pages of a small fixed pool are resident for one process. Each cycle it may accept one page reference. A reference to a resident page is a hit: the page is marked as touched in the current interval, and the resident set stays as it is. A reference to a page that is not resident is a fault. The block reports that fault together with the page number, and the page joins the resident set.

Each fault closes an interval. The interval length is the number of references since the previous fault, counting the faulting reference itself. The first interval is counted from reset. If this length is above a programmable threshold, the block trims the set in one step: every resident page that was not touched during the interval leaves the set, and those pages are reported as a one-cycle eviction mask. If the length is at or below the threshold, nothing is removed and the set only grows. Loading pages and writing them back are left to the logic around the block.

Top module: `pff_resident_mgr`

## Requirements
- R1: After synchronous reset the resident set equals the parameter INIT_RESIDENT (default bit mask 8'h19, bit i meaning page i). The threshold equals THRESH_INIT (default 2). The interval count is zero, no page counts as touched, and fault_valid and evict_mask are low.
- R2: A valid reference to a resident page leaves the resident set unchanged. In the following cycle fault_valid is low and evict_mask is zero.
- R3: A valid reference to a non-resident page sets fault_valid high in the following cycle, for exactly that cycle, with fault_page holding the referenced page number. From that cycle on, resident_set contains the page.
- R4: On a fault whose interval length is greater than the threshold, evict_mask shows every page that was resident and not touched since the previous fault. Those pages leave resident_set in the same cycle that evict_mask appears. The page that faulted at the previous fault counts as touched.
- R5: On a fault whose interval length is at most the threshold, evict_mask is zero and no page leaves the resident set.
- R6: evict_mask is non-zero only in a cycle in which fault_valid is high.
- R7: A write of thr_data with thr_we high changes the threshold from the next cycle on. A fault presented in the same cycle as the write is judged against the old threshold.
- R8: The interval count saturates at 2^CNT_W-1 and does not wrap. With the default CNT_W of 8, an interval of 300 references is judged as 255.
- R9: Cycles with ref_valid low change neither the interval count nor the resident set, and produce no fault or eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ref_valid | input | 1 | A page reference is presented this cycle |
| ref_page | input | 3 | Referenced page number |
| thr_we | input | 1 | Write enable for the threshold register |
| thr_data | input | 8 | New threshold value |
| fault_valid | output | 1 | One-cycle fault report for the previous cycle's reference |
| fault_page | output | 3 | Page number that faulted |
| evict_mask | output | 8 | Pages removed by the trim that goes with this fault |
| resident_set | output | 8 | Current resident set, bit i for page i |

## Verification
The assertions assume that ref_page is always inside the pool and that reset is held for at least one clock edge before the first reference. They also assume that thr_we and ref_valid never carry unknown values after reset. The bench drives every input at the falling edge from one task at a time, so each of these holds. It always chooses page numbers below the pool size, and it only makes a reference that is meant to fault after it has found a page that its own model shows as non-resident. That way no fault scenario is lost because every page happens to be resident.

// File: rtl/pff_pkg.sv
package pff_pkg;

    localparam int unsigned PAGES_DEF   = 8;
    localparam int unsigned CNT_W_DEF   = 8;
    localparam int unsigned PAGE_W_DEF  = $clog2(PAGES_DEF);

    typedef logic [PAGES_DEF-1:0]  page_mask_t;
    typedef logic [PAGE_W_DEF-1:0] page_id_t;

    // one registered result per accepted reference
    typedef struct packed {
        logic       fault;
        page_id_t   page;
        page_mask_t evict;
    } pff_result_t;

    // decoded view of the reference presented this cycle
    typedef struct packed {
        logic       valid;
        logic       fault;
        logic       trim;
        page_mask_t sel;
    } pff_ref_t;

    function automatic page_mask_t page_onehot(input page_id_t p);
        page_mask_t m;
        m = '0;
        m[p] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pff_interval_ctr.sv
module pff_interval_ctr #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             restart,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] gap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_inc;

    // saturating increment: the count never wraps back to a small value
    assign count_inc = (count_q == CNT_MAX) ? CNT_MAX : count_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)          count_q <= '0;
        else if (restart) count_q <= '0;
        else if (step)    count_q <= count_inc;
    end

    assign count = count_q;
    // length of the interval closed by a fault in this cycle
    assign gap   = count_inc;

    p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (step && !restart && count_q == CNT_MAX) |=> (count_q == CNT_MAX));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!step && !restart) |=> $stable(count_q));

    p_restart_zero_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> (count_q == '0));

endmodule

// File: rtl/pff_page_table.sv
module pff_page_table #(
    parameter int unsigned        PAGES         = 8,
    parameter logic [PAGES-1:0]   INIT_RESIDENT = 8'h19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_valid,
    input  logic [PAGES-1:0] ref_sel,
    input  logic             fault,
    input  logic             trim,
    output logic [PAGES-1:0] resident,
    output logic [PAGES-1:0] evict
);
    logic [PAGES-1:0] res_q;
    logic [PAGES-1:0] touched_q;

    for (genvar i = 0; i < PAGES; i++) begin : g_page
        logic drop;
        assign drop     = fault && trim && res_q[i] && !touched_q[i];
        assign evict[i] = drop;

        always_ff @(posedge clk) begin
            if (rst) begin
                res_q[i]     <= INIT_RESIDENT[i];
                touched_q[i] <= 1'b0;
            end else if (fault) begin
                res_q[i]     <= (res_q[i] && !drop) || ref_sel[i];
                touched_q[i] <= ref_sel[i];
            end else if (ref_valid && ref_sel[i]) begin
                touched_q[i] <= 1'b1;
            end
        end
    end

    assign resident = res_q;

    p_hit_keeps_set_r2: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && !fault) |=> (res_q == $past(res_q)));

    p_fault_adds_page_r3: assert property (@(posedge clk) disable iff (rst)
        fault |=> ((res_q & $past(ref_sel)) != '0));

    p_no_trim_grows_r5: assert property (@(posedge clk) disable iff (rst)
        (fault && !trim) |=> (($past(res_q) & ~res_q) == '0));

    p_idle_set_r9: assert property (@(posedge clk) disable iff (rst)
        !ref_valid |=> $stable(res_q));

endmodule

// File: rtl/pff_resident_mgr.sv
module pff_resident_mgr
    import pff_pkg::*;
#(
    parameter int unsigned            PAGES         = PAGES_DEF,
    parameter int unsigned            CNT_W         = CNT_W_DEF,
    parameter logic [PAGES-1:0]       INIT_RESIDENT = 8'h19,
    parameter logic [CNT_W-1:0]       THRESH_INIT   = 8'd2,
    localparam int unsigned           PAGE_W        = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_valid,
    input  logic [PAGE_W-1:0] ref_page,
    input  logic              thr_we,
    input  logic [CNT_W-1:0]  thr_data,
    output logic              fault_valid,
    output logic [PAGE_W-1:0] fault_page,
    output logic [PAGES-1:0]  evict_mask,
    output logic [PAGES-1:0]  resident_set
);
    logic [CNT_W-1:0] thr_q;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] gap;
    logic [PAGES-1:0] resident;
    logic [PAGES-1:0] evict;
    logic [PAGES-1:0] sel;
    logic             hit;
    logic             fault;
    logic             trim;

    logic              res_fault_q;
    logic [PAGE_W-1:0] res_page_q;
    logic [PAGES-1:0]  res_evict_q;

    always_comb begin
        sel = '0;
        sel[ref_page] = 1'b1;
    end

    assign hit   = resident[ref_page];
    assign fault = ref_valid && !hit;
    assign trim  = fault && (gap > thr_q);

    always_ff @(posedge clk) begin
        if (rst)         thr_q <= THRESH_INIT;
        else if (thr_we) thr_q <= thr_data;
    end

    pff_interval_ctr #(.CNT_W(CNT_W)) u_interval (
        .clk     (clk),
        .rst     (rst),
        .step    (ref_valid),
        .restart (fault),
        .count   (count),
        .gap     (gap)
    );

    pff_page_table #(.PAGES(PAGES), .INIT_RESIDENT(INIT_RESIDENT)) u_table (
        .clk       (clk),
        .rst       (rst),
        .ref_valid (ref_valid),
        .ref_sel   (sel),
        .fault     (fault),
        .trim      (trim),
        .resident  (resident),
        .evict     (evict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_fault_q <= 1'b0;
            res_page_q  <= '0;
            res_evict_q <= '0;
        end else begin
            res_fault_q <= fault;
            res_page_q  <= fault ? ref_page : res_page_q;
            res_evict_q <= evict;
        end
    end

    assign fault_valid  = res_fault_q;
    assign fault_page   = res_page_q;
    assign evict_mask   = res_evict_q;
    assign resident_set = resident;

    p_evict_only_fault_r6: assert property (@(posedge clk) disable iff (rst)
        !fault_valid |-> (evict_mask == '0));

    p_evicted_gone_r4: assert property (@(posedge clk) disable iff (rst)
        ((evict_mask & resident_set) == '0));

    p_fault_report_r3: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && !resident_set[ref_page]) |=>
            (fault_valid && fault_page == $past(ref_page)));

    p_fault_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> resident_set[fault_page]);

    p_thr_update_r7: assert property (@(posedge clk) disable iff (rst)
        thr_we |=> (thr_q == $past(thr_data)));

    p_count_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !ref_valid |=> (count == $past(count)));

endmodule

// File: tb/test_pff_resident_mgr.sv
module test_pff_resident_mgr;
    localparam int CLK_PERIOD = 10;
    localparam int NPG  = 8;
    localparam int MAXC = 255;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_valid = 1'b0;
    logic [2:0] ref_page = '0;
    logic       thr_we = 1'b0;
    logic [7:0] thr_data = '0;
    logic       fault_valid;
    logic [2:0] fault_page;
    logic [7:0] evict_mask;
    logic [7:0] resident_set;

    always #(CLK_PERIOD/2) clk = ~clk;

    pff_resident_mgr i_pff_resident_mgr (
        .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_page(ref_page),
        .thr_we(thr_we), .thr_data(thr_data), .fault_valid(fault_valid),
        .fault_page(fault_page), .evict_mask(evict_mask), .resident_set(resident_set)
    );

    typedef struct {
        bit         f;
        int         pg;
        logic [7:0] ev;
        logic [7:0] res;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] m_res = 8'h19;
    logic [7:0] m_refd = 8'h00;
    int         m_cnt = 0;
    int         m_thr = 2;
    logic [7:0] last_res = 8'h19;
    bit         pend = 0;
    bit         mon_on = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) pend <= ref_valid && !rst;

    // monitor: compares each result with the item queued by the driver
    always @(negedge clk) begin
        if (mon_on) begin
            if (pend) begin
                exp_t e;
                if (sb.size() == 0) begin
                    check(0, "R3", "result with empty scoreboard", 1, 0);
                end else begin
                    e = sb.pop_front();
                    check(fault_valid == e.f, e.tag, "fault_valid", fault_valid, e.f);
                    if (e.f) check(fault_page == e.pg[2:0], e.tag, "fault_page", fault_page, e.pg);
                    check(evict_mask == e.ev, e.f ? e.tag : "R6", "evict_mask", evict_mask, e.ev);
                    check(resident_set == e.res, e.tag, "resident_set", resident_set, e.res);
                    last_res = e.res;
                end
            end else begin
                check(fault_valid == 1'b0, "R9", "idle fault_valid", fault_valid, 0);
                check(evict_mask == 8'h00, "R6", "idle evict_mask", evict_mask, 0);
                check(resident_set == last_res, "R9", "idle resident_set", resident_set, last_res);
            end
        end
    end

    // driver: one reference per call; the model predicts the registered result
    task automatic do_ref(input int p, input string tag = "", input bit wthr = 0,
                          input int nt = 0);
        exp_t e;
        logic [7:0] s;
        int gap;
        @(negedge clk);
        ref_valid = 1'b1; ref_page = p[2:0]; thr_we = wthr; thr_data = nt[7:0];
        s = 8'h01 << p;
        e.pg = p;
        if (m_res[p]) begin
            m_refd = m_refd | s;
            m_cnt = (m_cnt >= MAXC) ? MAXC : m_cnt + 1;
            e.f = 0; e.ev = 8'h00;
            e.tag = (tag != "") ? tag : "R2";
        end else begin
            gap = (m_cnt >= MAXC) ? MAXC : m_cnt + 1;
            e.f = 1;
            e.ev = (gap > m_thr) ? (m_res & ~m_refd) : 8'h00;
            m_res = (m_res & ~e.ev) | s;
            m_refd = s;
            m_cnt = 0;
            e.tag = (tag != "") ? tag : ((e.ev != 0) ? "R4" : "R5");
        end
        e.res = m_res;
        if (wthr) m_thr = nt;
        sb.push_back(e);
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_valid = 1'b0; thr_we = 1'b0;
            @(posedge clk);
        end
    endtask

    task automatic set_thr(input int nt);
        @(negedge clk);
        ref_valid = 1'b0; thr_we = 1'b1; thr_data = nt[7:0];
        @(posedge clk);
        m_thr = nt;
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    function automatic int free_page(input int skip);
        for (int i = 0; i < NPG; i++)
            if (!m_res[i] && i != skip) return i;
        return -1;
    endfunction

    function automatic int used_page();
        for (int i = 0; i < NPG; i++)
            if (m_res[i]) return i;
        return 0;
    endfunction

    // shrink the set to two pages by trimming with a zero threshold
    task automatic flush();
        set_thr(0);
        do_ref(free_page(-1));
        do_ref(free_page(-1));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(resident_set == 8'h19, "R1", "reset resident_set", resident_set, 8'h19);
        check(fault_valid == 1'b0, "R1", "reset fault_valid", fault_valid, 0);
        check(evict_mask == 8'h00, "R1", "reset evict_mask", evict_mask, 0);
        mon_on = 1;

        // R4/R5 with the default threshold of 2: pages a..e map to 0..4
        do_ref(2); do_ref(2); do_ref(3); do_ref(1); do_ref(2);
        do_ref(4); do_ref(2); do_ref(4); do_ref(0); do_ref(3);
        idle(2);

        // R5: large threshold, back-to-back faults only grow the set
        flush();
        set_thr(5);
        do_ref(free_page(-1), "R5");
        do_ref(used_page(), "R2");
        do_ref(free_page(-1), "R5");
        idle(1);

        // R9: idle cycles do not lengthen the interval
        flush();
        set_thr(2);
        do_ref(free_page(-1));
        do_ref(used_page(), "R9");
        idle(10);
        do_ref(free_page(-1), "R9");

        // R7: threshold written in the same cycle as a fault uses the old value
        flush();
        set_thr(2);
        do_ref(used_page()); do_ref(used_page());
        do_ref(free_page(-1), "R7", 1, 7);
        do_ref(used_page()); do_ref(used_page());
        do_ref(free_page(-1), "R7");

        // R8: 300 hits saturate the count at 255, above a threshold of 254
        flush();
        set_thr(254);
        for (int i = 0; i < 300; i++) do_ref(used_page(), "R8");
        do_ref(free_page(-1), "R8");
        // R8: same length never exceeds a threshold of 255
        set_thr(255);
        for (int i = 0; i < 300; i++) do_ref(used_page(), "R8");
        do_ref(free_page(-1), "R8");
        idle(3);

        wait (sb.size() == 0);
        idle(1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule